// File: doc/BRIEF.md
# Signature-Compacting Self-Test Controller

This block runs a built-in self-test on a small combinational circuit. A pseudo-random pattern generator drives a 4-bit stimulus into the circuit under test. The circuit's 4-bit response comes back to a parallel-input signature register, which folds it into a running signature on every clock. A sequencer counts out a programmed number of test cycles and then compares the final signature with a golden value supplied at start. The result is reported as a one-cycle done pulse and a pass flag.

The test runs at full clock rate whenever the surrounding device is idle. Software or a test controller pulses start with a length and a golden signature, then waits for done. The signature depends on every response captured during the run, so a single wrong response bit in any cycle changes the result.

Top module: `bist_sig_ctrl`

## Requirements
- R1: After reset, done_o and pass_o are 0 and stim_o equals the pattern seed (default 4'b1000).
- R2: A start_i sampled high while idle loads the pattern seed and the signature seed (default 4'b0001), and latches test_len_i and golden_i. From the cycle after that edge, stim_o shows the pattern seed, and later changes to length or golden inputs have no effect on the run.
- R3: Bit 0 of the stimulus is stage 1 and bit 3 is stage 4. On each test cycle the pattern register shifts toward stage 4 and stage 1 takes stage 3 XOR stage 4. This gives a period of 15, and the register is never all-zero.
- R4: The signature register uses the same bit order. On each test cycle, stage 1 becomes (stage 3 XOR stage 4) XOR resp_i[0], and stage i (i = 2..4) becomes stage i-1 XOR resp_i[i-1]. The response is sampled at the same edge at which the pattern advances, so it is the response to the stimulus currently shown.
- R5: Exactly N test cycles follow the start edge, where N is the latched length. done_o is high for exactly one cycle, after the (N+1)th edge following the start edge. N = 0 captures nothing and compares the seed.
- R6: When done_o is high, pass_o is 1 if and only if the final signature equals the latched golden value.
- R7: pass_o holds its value from the end of a test until the next accepted start, which clears it.
- R8: A start_i pulse while a test is running is ignored; the run's length, timing and result are unchanged.
- R9: While idle, stim_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start request, accepted only when idle |
| test_len_i | input | LEN_W | Number of test cycles |
| golden_i | input | W | Expected final signature |
| resp_i | input | W | Response of the circuit under test |
| stim_o | output | W | Pattern driven into the circuit under test |
| done_o | output | 1 | One-cycle end-of-test pulse |
| pass_o | output | 1 | Test result, held until next start |

## Verification
The embedded assertions check on every cycle that:
- done is a single-cycle pulse;
- the cycle counter falls by one on each test cycle, even when start is asserted;
- the signature holds outside test cycles;
- the pattern register never reaches zero;
- pass changes only at a start or at a test end.

The actual stimulus sequence, the signature arithmetic, the exact done timing for several lengths including zero, and detection of a single injected response error can only be shown by the bench's scenarios. The bench compares these against its own model of the circuit under test.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} bist_state_e;

  // Feedback bit for a shift register with the given tap mask.
  function automatic logic tap_fb(input logic [3:0] st, input logic [3:0] taps);
    return ^(st & taps);
  endfunction
endpackage

// File: rtl/pattern_lfsr.sv
module pattern_lfsr #(
  parameter int          W    = 4,
  parameter logic [W-1:0] TAPS = 4'b1100,
  parameter logic [W-1:0] SEED = 4'b1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q, st_d;
  logic         fb;

  assign fb = ^(st_q & TAPS);

  always_comb begin
    st_d = st_q;
    if (load)      st_d = SEED;
    else if (step) st_d = {st_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R3: a maximal-length generator seeded nonzero never reaches zero
  p_never_zero_r3: assert property (@(posedge clk) disable iff (!rst_n) st_q != '0);
endmodule

// File: rtl/sig_misr.sv
module sig_misr #(
  parameter int           W    = 4,
  parameter logic [W-1:0] TAPS = 4'b1100,
  parameter logic [W-1:0] SEED = 4'b0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         cap,
  input  logic [W-1:0] resp,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] sig_q, sig_d, shifted;

  assign shifted[0] = ^(sig_q & TAPS);
  for (genvar i = 1; i < W; i++) begin : g_stage
    assign shifted[i] = sig_q[i-1];
  end

  always_comb begin
    sig_d = sig_q;
    if (load)     sig_d = SEED;
    else if (cap) sig_d = shifted ^ resp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= SEED;
    else        sig_q <= sig_d;
  end

  assign sig_o = sig_q;

  // R4: the signature only moves on a capture cycle or a seed load
  p_sig_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cap) |=> $stable(sig_q));
endmodule

// File: rtl/bist_seq.sv
module bist_seq #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             load_o,
  output logic             cap_o,
  output logic             finish_o
);
  import bist_pkg::*;

  bist_state_e      st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    load_o   = 1'b0;
    cap_o    = 1'b0;
    finish_o = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        load_o = 1'b1;
        cnt_d  = len;
        st_d   = ST_RUN;
      end
      ST_RUN: if (cnt_q == '0) begin
        finish_o = 1'b1;
        st_d     = ST_IDLE;
      end else begin
        cap_o = 1'b1;
        cnt_d = cnt_q - LEN_W'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // R8: a running count keeps falling whatever start does
  p_count_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && cnt_q != '0) |=> (st_q == ST_RUN && cnt_q == $past(cnt_q) - LEN_W'(1)));
  // R5: capture and finish never coincide with a load
  p_phase_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_o, cap_o, finish_o}));
endmodule

// File: rtl/bist_sig_ctrl.sv
module bist_sig_ctrl #(
  parameter int           W        = 4,
  parameter int           LEN_W    = 16,
  parameter logic [W-1:0] TAPS     = 4'b1100,
  parameter logic [W-1:0] PAT_SEED = 4'b1000,
  parameter logic [W-1:0] SIG_SEED = 4'b0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] test_len_i,
  input  logic [W-1:0]     golden_i,
  input  logic [W-1:0]     resp_i,
  output logic [W-1:0]     stim_o,
  output logic             done_o,
  output logic             pass_o
);
  logic [1:0]   rst_sync_q;
  logic         rst_s_n;
  logic         load, cap, finish;
  logic [W-1:0] sig;
  logic [W-1:0] gold_q, gold_d;
  logic         done_q, done_d, pass_q, pass_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  bist_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_s_n), .start(start_i), .len(test_len_i),
    .load_o(load), .cap_o(cap), .finish_o(finish)
  );

  pattern_lfsr #(.W(W), .TAPS(TAPS), .SEED(PAT_SEED)) u_pat (
    .clk(clk), .rst_n(rst_s_n), .load(load), .step(cap), .state_o(stim_o)
  );

  sig_misr #(.W(W), .TAPS(TAPS), .SEED(SIG_SEED)) u_sig (
    .clk(clk), .rst_n(rst_s_n), .load(load), .cap(cap), .resp(resp_i), .sig_o(sig)
  );

  always_comb begin
    gold_d = load ? golden_i : gold_q;
    done_d = finish;
    pass_d = pass_q;
    if (load)        pass_d = 1'b0;
    else if (finish) pass_d = (sig == gold_q);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      gold_q <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      gold_q <= gold_d;
      done_q <= done_d;
      pass_q <= pass_d;
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_q |=> !done_q);
  // R7: the result moves only at a start or at the end of a test
  p_pass_hold_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!load && !finish) |=> $stable(pass_q));
  // R6: a pass can only appear together with done
  p_pass_on_done_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(pass_q) |-> done_q);
endmodule

// File: tb/tb_bist_sig_ctrl.sv
module tb_bist_sig_ctrl;
  localparam logic [3:0] PSEED = 4'b1000;
  localparam logic [3:0] SSEED = 4'b0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] test_len_i = '0;
  logic [3:0]  golden_i = '0;
  logic [3:0]  resp_i;
  logic [3:0]  stim_o;
  logic        done_o, pass_o;
  logic        fault_en = 1'b0;
  int          tests = 0;
  int          fails = 0;

  always #4 clk = ~clk;

  bist_sig_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .test_len_i(test_len_i),
    .golden_i(golden_i), .resp_i(resp_i), .stim_o(stim_o),
    .done_o(done_o), .pass_o(pass_o)
  );

  // circuit under test model, with an optional single-pattern fault
  function automatic logic [3:0] cut(input logic [3:0] p);
    return {p[2] ^ p[0], p[3] & p[1], ~p[1], p[0] | p[3]};
  endfunction

  always_comb resp_i = cut(stim_o) ^ ((fault_en && stim_o == PSEED) ? 4'b0001 : 4'b0000);

  function automatic logic [3:0] m_step(input logic [3:0] p);
    return {p[2:0], p[3] ^ p[2]};
  endfunction

  function automatic logic [3:0] m_sig(input logic [3:0] s, input logic [3:0] r);
    return {s[2:0], s[3] ^ s[2]} ^ r;
  endfunction

  function automatic logic [3:0] good_sig(input int n);
    logic [3:0] s = SSEED;
    logic [3:0] p = PSEED;
    for (int k = 0; k < n; k++) begin
      s = m_sig(s, cut(p));
      p = m_step(p);
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one test; mid > 0 pulses start again in that test cycle.
  task automatic run_test(input int len, input logic [3:0] gold, input bit exp_pass,
                          input bit flt, input int mid);
    logic [3:0] p = PSEED;
    fault_en = flt;
    @(negedge clk);
    start_i = 1'b1; test_len_i = 16'(len); golden_i = gold;
    @(negedge clk);
    start_i = 1'b0; test_len_i = 16'(len + 3); golden_i = ~gold;
    check(stim_o == PSEED, "R2 seed on stim", stim_o, PSEED);
    check(pass_o == 1'b0, "R7 pass cleared at start", pass_o, 0);
    for (int k = 1; k <= len + 1; k++) begin
      start_i = (k == mid);
      @(negedge clk);
      if (k <= len) begin
        p = m_step(p);
        check(done_o == 1'b0, "R5 no early done", done_o, 0);
        check(stim_o == p, "R3 pattern step", stim_o, p);
      end else begin
        check(done_o == 1'b1, "R5 done timing", done_o, 1);
        check(pass_o == exp_pass, "R6 pass result", pass_o, exp_pass);
        check(stim_o == p, "R9 stim hold at end", stim_o, p);
      end
    end
    start_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, "R5 done one cycle", done_o, 0);
    check(pass_o == exp_pass, "R7 pass held", pass_o, exp_pass);
    fault_en = 1'b0;
  endtask

  task automatic t_reset;
    check(done_o == 1'b0, "R1 done reset", done_o, 0);
    check(pass_o == 1'b0, "R1 pass reset", pass_o, 0);
    check(stim_o == PSEED, "R1 stim reset", stim_o, PSEED);
  endtask

  task automatic t_good;        run_test(10, good_sig(10), 1'b1, 1'b0, 0); endtask // R4 R6
  task automatic t_bad_golden;  run_test(10, good_sig(10) ^ 4'b0100, 1'b0, 1'b0, 0); endtask // R6
  task automatic t_fault;       run_test(10, good_sig(10), 1'b0, 1'b1, 0); endtask // R4
  task automatic t_zero_len;    run_test(0, SSEED, 1'b1, 1'b0, 0); endtask // R5
  task automatic t_len_one;     run_test(1, good_sig(1), 1'b1, 1'b0, 0); endtask // R5
  task automatic t_long;        run_test(40, good_sig(40), 1'b1, 1'b0, 0); endtask // R3 period
  task automatic t_ignore_start; run_test(8, good_sig(8), 1'b1, 1'b0, 3); endtask // R8

  task automatic t_pass_hold;
    logic [3:0] s;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(pass_o == 1'b1, "R7 pass holds idle", pass_o, 1);
      check(done_o == 1'b0, "R5 no stray done", done_o, 0);
    end
    s = stim_o;
    repeat (3) @(negedge clk);
    check(stim_o == s, "R9 stim idle hold", stim_o, s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_good();
    t_pass_hold();
    t_bad_golden();
    t_fault();
    t_zero_len();
    t_len_one();
    t_ignore_start();
    t_long();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule